// File: doc/BRIEF.md
# Time-Slot Synchronous Transfer Interrupt Unit

This block raises interrupts at fixed points of a time-division-multiplexed serial frame. The system clock is the serial data clock. Two data-clock cycles make one bit clock, eight bit clocks make one time slot, and the number of slots per frame is a parameter. A frame-sync input restarts the position count. Four channels each have their own trigger slot, overflow-check slot and position-select bit. When a channel's trigger point passes, the block sets that channel's transfer interrupt and marks the channel as waiting for an acknowledge.

Software acknowledges a channel with a one-cycle strobe. If the channel is still waiting when its deadline point is reached, and overflow reporting is enabled for that channel, the block sets the channel's overflow interrupt. Software reads all eight interrupt bits as one byte, and the read clears them. A single interrupt line is high while any bit is set.

Top module: `slotirq_top`

## Requirements
- R1: After reset the status byte is 0x00 and `irq` is low.
- R2: Status layout: bit 4+c is the overflow interrupt of channel c, and bit c is the transfer interrupt of channel c, for c = 0..3.
- R3: In a cycle with `rdStb` high, `statusData` shows the current bits, and every bit is zero after that clock edge unless a new event sets it in the same cycle.
- R4: The bit-clock position is (data cycles since the sync edge)/2, modulo SLOTS*8. The transfer bit of channel c is set at the clock edge that ends the first data cycle at bit position ((trigSlot+1)*8 + 2) mod frame when posSel[c]=0, or ((trigSlot+1)*8 + 1) mod frame when posSel[c]=1.
- R5: The deadline of channel c is the first data cycle at bit position (ovSlot*8 - 1) mod frame when posSel[c]=0, or ovSlot*8 when posSel[c]=1. At the edge ending that cycle, the overflow bit is set if the channel is still waiting for an acknowledge. Each deadline ends the wait.
- R6: The overflow bit of a channel never sets while `ovEn` for that channel is low.
- R7: An `ackStb` pulse ends the channel's wait, so no overflow follows. An acknowledge in the deadline cycle itself counts as in time. An acknowledge while nothing is waiting has no effect.
- R8: A `frameSync` pulse sets the position to zero at the next edge, whatever the current position.
- R9: When a read and a new event fall in the same cycle, the new event's bit is set after the edge and nothing is lost.
- R10: `irq` is high exactly when the status byte is non-zero.
- R11: A trigger in the same cycle as an acknowledge of the same channel leaves the channel waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Frame start pulse; restarts the position |
| trigSlot | input | 4*SLOT_W | Trigger time slot per channel, channel c at [c*SLOT_W +: SLOT_W] |
| ovSlot | input | 4*SLOT_W | Overflow-check time slot per channel |
| posSel | input | 4 | Position-select bit per channel |
| ovEn | input | 4 | Overflow enable per channel |
| ackStb | input | 4 | One-cycle acknowledge per channel |
| rdStb | input | 1 | Status read strobe; clears the status |
| statusData | output | 8 | Interrupt status byte |
| irq | output | 1 | OR of all status bits |

## Verification
Two pairs of functions can fall in the same cycle. A status read can coincide with a new trigger or overflow event, and an acknowledge can coincide with a channel's trigger or deadline. The sweep drives reads and acknowledges on periods that do not divide the frame length, so across the configurations they land on event cycles. The bench also steers each pair onto the exact event cycle once on purpose. Each outcome is judged against a cycle model in the bench. In that model the read loses to a new event, and an acknowledge wins over a deadline but loses to a trigger.

// File: rtl/slotirq_pkg.sv
package slotirq_pkg;

  localparam int NUM_CH = 4;

  // Event strobes produced by the control half for the datapath half
  typedef struct packed {
    logic [NUM_CH-1:0] trig;
    logic [NUM_CH-1:0] dead;
  } evStb_t;

endpackage

// File: rtl/slotirq_ctrl.sv
module slotirq_ctrl
  import slotirq_pkg::*;
#(
  parameter int SLOTS       = 4,
  parameter int SLOT_BITS   = 8,
  parameter int DCL_PER_BCL = 2,
  parameter int SLOT_W      = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameSync,
  input  logic [NUM_CH*SLOT_W-1:0] trigSlot,
  input  logic [NUM_CH*SLOT_W-1:0] ovSlot,
  input  logic [NUM_CH-1:0]        posSel,
  output evStb_t                   stb
);

  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int FRAME_DCL  = FRAME_BITS * DCL_PER_BCL;
  localparam int POS_W      = (FRAME_DCL > 1) ? $clog2(FRAME_DCL) : 1;

  logic [POS_W-1:0] pos;
  logic             posWrap;

  assign posWrap = (pos == POS_W'(FRAME_DCL - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pos <= '0;
    else if (frameSync) pos <= '0;
    else if (posWrap)   pos <= '0;
    else                pos <= pos + 1'b1;
  end

  // Trigger point: one or two bit clocks after the end of the selected slot
  function automatic logic [POS_W-1:0] trigPos(input logic [SLOT_W-1:0] s, input logic d);
    int b;
    b = ((int'(s) + 1) * SLOT_BITS + (d ? 1 : 2)) % FRAME_BITS;
    return POS_W'(b * DCL_PER_BCL);
  endfunction

  // Deadline point: one or zero bit clocks before the start of the selected slot
  function automatic logic [POS_W-1:0] deadPos(input logic [SLOT_W-1:0] s, input logic d);
    int b;
    b = (int'(s) * SLOT_BITS + FRAME_BITS - (d ? 0 : 1)) % FRAME_BITS;
    return POS_W'(b * DCL_PER_BCL);
  endfunction

  logic [NUM_CH-1:0] trigHit;
  logic [NUM_CH-1:0] deadHit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign trigHit[c] = (pos == trigPos(trigSlot[c*SLOT_W +: SLOT_W], posSel[c]));
    assign deadHit[c] = (pos == deadPos(ovSlot[c*SLOT_W +: SLOT_W], posSel[c]));
  end

  assign stb.trig = trigHit;
  assign stb.dead = deadHit;

  // R8
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> pos == '0);

  // R4
  pos_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && !posWrap) |=> pos == $past(pos) + 1'b1);

endmodule

// File: rtl/slotirq_dp.sv
module slotirq_dp
  import slotirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  evStb_t            stb,
  input  logic [NUM_CH-1:0] ovEn,
  input  logic [NUM_CH-1:0] ackStb,
  input  logic              rdStb,
  output logic [2*NUM_CH-1:0] statusData
);

  logic [NUM_CH-1:0]   xferBits;
  logic [NUM_CH-1:0]   ovBits;
  logic [NUM_CH-1:0]   pend;
  logic [NUM_CH-1:0]   pendNext;
  logic [NUM_CH-1:0]   trigIn;
  logic [NUM_CH-1:0]   deadIn;
  logic [NUM_CH-1:0]   ovSet;
  logic [2*NUM_CH-1:0] statusReg;
  logic [2*NUM_CH-1:0] statusNext;

  assign trigIn = stb.trig;
  assign deadIn = stb.dead;

  // Late only if still waiting, not acknowledged this cycle, and enabled
  assign ovSet = deadIn & pend & ~ackStb & ovEn;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
    always_comb begin
      if (trigIn[c])                   pendNext[c] = 1'b1;
      else if (ackStb[c] || deadIn[c]) pendNext[c] = 1'b0;
      else                             pendNext[c] = pend[c];
    end
  end

  // A read clears old bits; same-cycle events survive it
  assign statusNext = (rdStb ? '0 : statusReg) | {ovSet, trigIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
      pend      <= '0;
    end else begin
      statusReg <= statusNext;
      pend      <= pendNext;
    end
  end

  assign xferBits   = statusReg[NUM_CH-1:0];
  assign ovBits     = statusReg[2*NUM_CH-1:NUM_CH];
  assign statusData = statusReg;

  // R3
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !(|trigIn) && !(|ovSet)) |=> statusReg == '0);

  // R6
  ov_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (ovBits & ~$past(ovBits) & ~$past(ovEn)) == '0);

  // R4
  xfer_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (xferBits & ~$past(xferBits) & ~$past(trigIn)) == '0);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pend & $past(ackStb & ~trigIn)) == '0);

  // R9
  keep_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($past(trigIn) & ~xferBits) == '0);

endmodule

// File: rtl/slotirq_top.sv
module slotirq_top
  import slotirq_pkg::*;
#(
  parameter int SLOTS       = 4,
  parameter int SLOT_BITS   = 8,
  parameter int DCL_PER_BCL = 2,
  localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameSync,
  input  logic [NUM_CH*SLOT_W-1:0] trigSlot,
  input  logic [NUM_CH*SLOT_W-1:0] ovSlot,
  input  logic [NUM_CH-1:0]        posSel,
  input  logic [NUM_CH-1:0]        ovEn,
  input  logic [NUM_CH-1:0]        ackStb,
  input  logic                     rdStb,
  output logic [2*NUM_CH-1:0]      statusData,
  output logic                     irq
);

  evStb_t evStb;

  slotirq_ctrl #(
    .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .DCL_PER_BCL(DCL_PER_BCL), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .trigSlot(trigSlot), .ovSlot(ovSlot), .posSel(posSel), .stb(evStb)
  );

  slotirq_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(evStb), .ovEn(ovEn),
    .ackStb(ackStb), .rdStb(rdStb), .statusData(statusData)
  );

  assign irq = |statusData;

  // R10
  irq_or_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> statusData != '0);

endmodule

// File: tb/slotirq_top_tb.sv
module slotirq_top_tb;

  localparam int SB = 8;
  localparam int FB = 4 * SB;
  localparam int DPB = 2;
  localparam int FD = FB * DPB;

  logic       clk = 1'b0;
  logic       rstN;
  logic       frameSync;
  logic [7:0] trigSlot;
  logic [7:0] ovSlot;
  logic [3:0] posSel;
  logic [3:0] ovEn;
  logic [3:0] ackStb;
  logic       rdStb;
  logic [7:0] statusData;
  logic       irq;

  int checks = 0;
  int errors = 0;

  int         mPos;
  logic [7:0] mStat;
  logic [3:0] mPend;

  always #2 clk = ~clk;

  slotirq_top u_dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .trigSlot(trigSlot),
    .ovSlot(ovSlot), .posSel(posSel), .ovEn(ovEn), .ackStb(ackStb),
    .rdStb(rdStb), .statusData(statusData), .irq(irq)
  );

  function automatic int tPos(int s, bit d);
    return ((((s + 1) * SB) + (d ? 1 : 2)) % FB) * DPB;
  endfunction

  function automatic int dPos(int s, bit d);
    return ((s * SB + FB - (d ? 0 : 1)) % FB) * DPB;
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs are set at the negedge; advance one edge and compare at the next negedge
  task automatic tick(bit doCmp);
    logic [3:0] tr, dl, ovs, pn;
    logic [7:0] nStat;
    int nPos;
    for (int c = 0; c < 4; c++) begin
      tr[c] = (mPos == tPos(int'(trigSlot[c*2 +: 2]), posSel[c]));
      dl[c] = (mPos == dPos(int'(ovSlot[c*2 +: 2]), posSel[c]));
    end
    ovs = dl & mPend & ~ackStb & ovEn;
    for (int c = 0; c < 4; c++)
      pn[c] = tr[c] ? 1'b1 : ((ackStb[c] | dl[c]) ? 1'b0 : mPend[c]);
    nStat = (rdStb ? 8'h00 : mStat) | {ovs, tr};
    nPos  = frameSync ? 0 : ((mPos == FD - 1) ? 0 : mPos + 1);
    @(posedge clk);
    mPos = nPos; mStat = nStat; mPend = pn;
    @(negedge clk);
    frameSync = 1'b0; ackStb = 4'h0; rdStb = 1'b0;
    if (doCmp) begin
      check(statusData[3:0] == mStat[3:0], "R4 transfer bits", statusData, mStat);
      check(statusData[7:4] == mStat[7:4], "R5/R6/R7 overflow bits", statusData, mStat);
      check(irq == (mStat != 8'h00), "R10 irq", {7'h0, irq}, {7'h0, mStat != 8'h00});
    end
  endtask

  task automatic runTo(int p);
    while (mPos != p) tick(1'b1);
  endtask

  task automatic syncNow();
    frameSync = 1'b1;
    tick(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; frameSync = 1'b0; rdStb = 1'b0; ackStb = 4'h0;
    trigSlot = 8'h00; ovSlot = 8'h00; posSel = 4'h0; ovEn = 4'h0;
    mPos = 0; mStat = 8'h00; mPend = 4'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(statusData == 8'h00, "R1 status after reset", statusData, 8'h00);
    check(irq == 1'b0, "R1 irq after reset", {7'h0, irq}, 8'h00);
    rstN = 1'b1;

    // R8 + R4: latency from a mid-frame sync, channel 0 slot 1, posSel 0
    trigSlot = 8'b00_00_00_01; ovSlot = 8'h00; posSel = 4'h0; ovEn = 4'h0;
    repeat (5) tick(1'b1);
    syncNow();
    for (int k = 1; k < tPos(1, 1'b0) + 1; k++) tick(1'b1);
    check(statusData[0] == 1'b0, "R8 no transfer before trigger point", statusData, 8'h00);
    tick(1'b1);
    check(statusData[0] == 1'b1, "R4 transfer at ((1+1)*8+2)*2 cycles after sync", statusData, 8'h01);
    check(statusData[7:4] == 4'h0, "R2 overflow half untouched", statusData, 8'h01);

    // R3: read with no event clears everything
    rdStb = 1'b1;
    tick(1'b1);
    check(statusData == 8'h00, "R3 read clears status", statusData, 8'h00);

    // R9: read in the very cycle of a trigger keeps the new bit
    posSel = 4'h1;
    runTo(tPos(1, 1'b1));
    rdStb = 1'b1;
    tick(1'b1);
    check(statusData == 8'h01, "R9 event kept over read", statusData, 8'h01);
    rdStb = 1'b1; tick(1'b1);

    // R11: acknowledge in the trigger cycle leaves the wait; overflow follows
    ovEn = 4'h1; ovSlot = 8'b00_00_00_11;
    runTo(tPos(1, 1'b1));
    ackStb = 4'h1;
    tick(1'b1);
    runTo(dPos(3, 1'b1));
    tick(1'b1);
    check(statusData[4] == 1'b1, "R11 overflow after ack lost to trigger", statusData, 8'h10);
    rdStb = 1'b1; tick(1'b1);

    // R7: acknowledge exactly in the deadline cycle is in time
    runTo(dPos(3, 1'b1));
    ackStb = 4'h1;
    tick(1'b1);
    check(statusData[4] == 1'b0, "R7 ack at deadline prevents overflow", statusData, 8'h00);
    // R7: acknowledge with nothing pending has no effect, next trigger then overflows
    ackStb = 4'h1; tick(1'b1);
    runTo(dPos(3, 1'b1));
    tick(1'b1);
    check(statusData[4] == 1'b1, "R7 idle ack harmless, later overflow", statusData, 8'h11);
    rdStb = 1'b1; tick(1'b1);

    // R6: overflow disabled never sets
    ovEn = 4'h0;
    runTo(dPos(3, 1'b1));
    tick(1'b1);
    check(statusData[4] == 1'b0, "R6 overflow gated off", statusData, 8'h00);

    // Sweep over slot rotations and all position-select patterns
    for (int ps = 0; ps < 16; ps++) begin
      for (int k = 0; k < 4; k++) begin
        for (int c = 0; c < 4; c++) begin
          trigSlot[c*2 +: 2] = 2'((c + k) % 4);
          ovSlot[c*2 +: 2]   = 2'((c + k + 2) % 4);
        end
        posSel = 4'(ps);
        ovEn   = (k == 3) ? 4'b1010 : 4'b1111;
        for (int cyc = 0; cyc < 3 * FD; cyc++) begin
          if (cyc == 70 && k == 1) frameSync = 1'b1;
          if (cyc % 7 == ps % 7) rdStb = 1'b1;
          for (int c = 0; c < 4; c++)
            if (cyc % 11 == (2 * c + k) % 11) ackStb[c] = 1'b1;
          tick(1'b1);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule